// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns one read or write command for a synchronous DRAM into the per-cycle column stream of its burst. A mode command first stores the burst length, the column ordering and the read latency. Each later read or write command carries a bank number and a starting column. From the clock edge that samples the command, the block drives one beat per cycle: the bank, the column for that beat, an active flag and a write strobe. A read-valid flag follows the issued read beats, delayed by the stored latency.

The memory has four banks and a 512-column row of 16-bit locations. A burst can be stopped by a terminate command. It can also be replaced on any cycle by a fresh read or write command, with no spacing rule between commands. The stored setting cannot change while a burst or its pending read data is in flight.

Top module: `sdr_burst_seq`

## Requirements
- R1: After synchronous reset, act_o and rd_valid_o are low. The stored setting is then burst length 1, sequential order and read latency 3.
- R2: Command codes on cmd_i are 0 no-op, 1 mode write, 2 read, 3 write and 4 terminate; any other code acts as a no-op. A read or write sampled at a rising edge puts its first beat on the outputs right after that edge: act_o high, bank_o and col_o equal to the command's bank and column, and wr_o high for a write and low for a read. One beat follows per cycle after that.
- R3: cfg_len_i codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. act_o falls on the cycle after the last beat.
- R4: In sequential order (cfg_ilv_i = 0), beat j has column bits above the burst block taken from the start column. Its low bits inside the block are (start + j) modulo the burst length.
- R5: In interleaved order (cfg_ilv_i = 1), beat j has its low block bits equal to the start's low bits XOR j. The upper bits are kept.
- R6: cfg_len_i code 7 selects a full-page burst. Its columns are (start + j) modulo 512, the ordering input is ignored, and the burst runs until it is terminated or replaced.
- R7: cfg_lat_i = 3 selects latency 3, and any other value selects latency 2. A read beat shown after edge k raises rd_valid_o in the cycle after edge k + latency - 1. Write beats never raise rd_valid_o.
- R8: A terminate command drops act_o right after the edge that samples it. Read beats already issued still produce their rd_valid_o cycles.
- R9: A read or write command sampled during any beat of a running burst starts the new burst at once. The old burst stops, and read-valid cycles of old read beats still arrive.
- R10: A mode write is ignored while act_o is high or any issued read beat has not yet produced its rd_valid_o cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Command code |
| bank_i | input | 2 | Bank for a read or write |
| col_i | input | 9 | Starting column for a read or write |
| cfg_len_i | input | 3 | Burst length code for a mode write |
| cfg_ilv_i | input | 1 | Ordering for a mode write, 1 = interleaved |
| cfg_lat_i | input | 2 | Read latency for a mode write |
| act_o | output | 1 | A burst beat is presented this cycle |
| wr_o | output | 1 | Current beat is a write |
| bank_o | output | 2 | Bank of the current beat |
| col_o | output | 9 | Column of the current beat |
| rd_valid_o | output | 1 | Read data for an earlier beat is due this cycle |

## Verification
Two functions share a cycle in several cases. A preempting command or a terminate arrives on the same edge where read-valid cycles from the old burst are still leaving the latency pipeline. A mode write can also arrive while beats are running or while the pipeline is draining. The bench provokes these by issuing the second command at a chosen beat index. It then checks, cycle by cycle, that the new beats carry the new bank, column and strobe, and that the old read-valid cycles keep arriving at their latency offsets. For a rejected mode write, a later burst must still show the old length and latency.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    localparam int COL_W   = 9;
    localparam int BANK_W  = 2;
    localparam int LAT_MAX = 3;
    localparam int LAT_MIN = 2;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_MODE  = 3'd1,
        CMD_READ  = 3'd2,
        CMD_WRITE = 3'd3,
        CMD_TERM  = 3'd4
    } cmd_e;

    // stored burst setting
    typedef struct packed {
        logic [2:0] len;
        logic       ilv;
        logic       lat3;
    } mode_t;

    // running burst context
    typedef struct packed {
        logic              act;
        logic              wr;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  start;
        logic [COL_W-1:0]  cnt;
    } beat_t;

    function automatic logic is_full(input logic [2:0] code);
        return code == 3'd7;
    endfunction

    // mask of the column bits that move inside one burst block
    function automatic logic [COL_W-1:0] len_mask(input logic [2:0] code);
        logic [COL_W-1:0] m;
        case (code)
            3'd0, 3'd1, 3'd2, 3'd3: m = (COL_W'(1) << code) - COL_W'(1);
            3'd7:                   m = '1;
            default:                m = '0;
        endcase
        return m;
    endfunction

    function automatic logic [COL_W-1:0] col_of(
        input logic [COL_W-1:0] start,
        input logic [COL_W-1:0] cnt,
        input logic [COL_W-1:0] mask,
        input logic             ilv
    );
        logic [COL_W-1:0] low;
        low = ilv ? (start ^ cnt) : (start + cnt);
        return (start & ~mask) | (low & mask);
    endfunction

endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
    import sdr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we_i,
    input  logic [2:0] len_i,
    input  logic       ilv_i,
    input  logic [1:0] lat_i,
    output mode_t      mode_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o <= '{len: 3'd0, ilv: 1'b0, lat3: 1'b1};
        end else if (we_i) begin
            mode_o <= '{len: len_i, ilv: ilv_i, lat3: (lat_i == 2'd3)};
        end
    end
endmodule

// File: rtl/sdr_beat_ctl.sv
module sdr_beat_ctl
    import sdr_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [COL_W-1:0]  col_i,
    input  mode_t             mode_i,
    output beat_t             beat_o,
    output logic              nxt_rd_o
);
    beat_t            nxt;
    logic [COL_W-1:0] mask;
    logic             full;

    assign mask = len_mask(mode_i.len);
    assign full = is_full(mode_i.len);

    always_comb begin
        nxt = beat_o;
        case (cmd_e'(cmd_i))
            CMD_READ, CMD_WRITE: begin
                nxt.act   = 1'b1;
                nxt.wr    = (cmd_e'(cmd_i) == CMD_WRITE);
                nxt.bank  = bank_i;
                nxt.start = col_i;
                nxt.cnt   = '0;
            end
            CMD_TERM: nxt.act = 1'b0;
            default: begin
                if (beat_o.act) begin
                    if (!full && beat_o.cnt == mask) nxt.act = 1'b0;
                    else                             nxt.cnt = beat_o.cnt + COL_W'(1);
                end
            end
        endcase
    end

    assign nxt_rd_o = nxt.act & ~nxt.wr;

    always_ff @(posedge clk) begin
        if (rst) beat_o <= '0;
        else     beat_o <= nxt;
    end
endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
    parameter int DEPTH = 3,
    parameter int LO    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic in_i,
    input  logic long_i,
    output logic out_o,
    output logic busy_o
);
    localparam int IDX_LO = LO - 1;
    localparam int IDX_HI = DEPTH - 1;

    logic [DEPTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[DEPTH-2:0], in_i};
    end

    assign out_o  = long_i ? stg[IDX_HI] : stg[IDX_LO];
    assign busy_o = |stg;
endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
    import sdr_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [2:0]        cfg_len_i,
    input  logic              cfg_ilv_i,
    input  logic [1:0]        cfg_lat_i,
    output logic              act_o,
    output logic              wr_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [COL_W-1:0]  col_o,
    output logic              rd_valid_o
);
    mode_t mode_q;
    beat_t beat_q;
    logic  nxt_rd;
    logic  pipe_busy;
    logic  mode_we;

    assign mode_we = (cmd_e'(cmd_i) == CMD_MODE) && !beat_q.act && !pipe_busy;

    sdr_mode_reg u_mode (
        .clk    (clk),
        .rst    (rst),
        .we_i   (mode_we),
        .len_i  (cfg_len_i),
        .ilv_i  (cfg_ilv_i),
        .lat_i  (cfg_lat_i),
        .mode_o (mode_q)
    );

    sdr_beat_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .cmd_i    (cmd_i),
        .bank_i   (bank_i),
        .col_i    (col_i),
        .mode_i   (mode_q),
        .beat_o   (beat_q),
        .nxt_rd_o (nxt_rd)
    );

    sdr_rd_pipe #(.DEPTH(LAT_MAX), .LO(LAT_MIN)) u_pipe (
        .clk    (clk),
        .rst    (rst),
        .in_i   (nxt_rd),
        .long_i (mode_q.lat3),
        .out_o  (rd_valid_o),
        .busy_o (pipe_busy)
    );

    assign act_o  = beat_q.act;
    assign wr_o   = beat_q.wr;
    assign bank_o = beat_q.bank;
    assign col_o  = col_of(beat_q.start, beat_q.cnt, len_mask(mode_q.len),
                           mode_q.ilv & ~is_full(mode_q.len));
endmodule

// File: rtl/sdr_burst_seq_chk.sv
module sdr_burst_seq_chk
    import sdr_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [2:0]        cmd_i,
    input logic [BANK_W-1:0] bank_i,
    input logic [COL_W-1:0]  col_i,
    input logic              act_o,
    input logic              wr_o,
    input logic [BANK_W-1:0] bank_o,
    input logic [COL_W-1:0]  col_o,
    input logic              rd_valid_o,
    input logic              lat3
);
    a_r1_idle_after_reset: assert property (@(posedge clk)
        rst |=> (!act_o && !rd_valid_o));

    a_r9_read_takes_over: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == CMD_READ) |=> (act_o && !wr_o && col_o == $past(col_i) && bank_o == $past(bank_i)));

    a_r9_write_takes_over: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == CMD_WRITE) |=> (act_o && wr_o && col_o == $past(col_i) && bank_o == $past(bank_i)));

    a_r8_term_stops: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == CMD_TERM) |=> !act_o);

    a_r7_lat2_valid: assert property (@(posedge clk) disable iff (rst)
        (act_o && !wr_o && !lat3) |=> rd_valid_o);

    a_r7_lat3_valid: assert property (@(posedge clk) disable iff (rst)
        (act_o && !wr_o && lat3) |-> ##2 rd_valid_o);
endmodule

bind sdr_burst_seq sdr_burst_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_i      (cmd_i),
    .bank_i     (bank_i),
    .col_i      (col_i),
    .act_o      (act_o),
    .wr_o       (wr_o),
    .bank_o     (bank_o),
    .col_o      (col_o),
    .rd_valid_o (rd_valid_o),
    .lat3       (mode_q.lat3)
);

// File: tb/sim_sdr_burst_seq.sv
module sim_sdr_burst_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cmd_i = 3'd0;
    logic [1:0] bank_i = '0;
    logic [8:0] col_i = '0;
    logic [2:0] cfg_len_i = '0;
    logic       cfg_ilv_i = 1'b0;
    logic [1:0] cfg_lat_i = 2'd3;
    logic       act_o, wr_o, rd_valid_o;
    logic [1:0] bank_o;
    logic [8:0] col_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdr_burst_seq u0 (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .bank_i(bank_i), .col_i(col_i),
        .cfg_len_i(cfg_len_i), .cfg_ilv_i(cfg_ilv_i), .cfg_lat_i(cfg_lat_i),
        .act_o(act_o), .wr_o(wr_o), .bank_o(bank_o), .col_o(col_o),
        .rd_valid_o(rd_valid_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    // drive inputs at a falling edge, pass one rising edge, land on the next falling edge
    task automatic step(input int c, input int b, input int col);
        cmd_i  = 3'(c);
        bank_i = 2'(b);
        col_i  = 9'(col);
        @(posedge clk);
        @(negedge clk);
        cmd_i  = 3'd0;
    endtask

    task automatic set_mode(input int code, input int ilv, input int lat);
        cfg_len_i = 3'(code);
        cfg_ilv_i = ilv[0];
        cfg_lat_i = 2'(lat);
        step(1, 0, 0);
    endtask

    function automatic int exp_col(input int start, input int j, input int blen, input int ilv);
        int m = blen - 1;
        int low = ilv ? ((start ^ j) & m) : ((start + j) & m);
        return ((start & ~m) | low) & 511;
    endfunction

    task automatic burst(input int code, input int ilv, input int lat,
                         input int start, input int wr, input int b);
        int blen = 1 << code;
        set_mode(code, ilv, lat);
        step(wr ? 3 : 2, b, start);
        for (int j = 0; j <= blen + lat; j++) begin
            chk("R3 act", act_o, j < blen);
            if (j < blen) begin
                chk(ilv ? "R5 col" : "R4 col", col_o, exp_col(start, j, blen, ilv));
                chk("R2 bank", bank_o, b);
                chk("R2 wr", wr_o, wr);
            end
            chk("R7 rd_valid", rd_valid_o, (!wr && j >= lat - 1 && j < blen + lat - 1));
            step(0, 0, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        step(0, 0, 0);
        rst = 1'b0;
        chk("R1 act after reset", act_o, 0);
        chk("R1 rd_valid after reset", rd_valid_o, 0);

        // default setting: one beat, latency 3
        step(2, 1, 5);
        chk("R1 default first beat act", act_o, 1);
        chk("R1 default col", col_o, 5);
        chk("R1 default bank", bank_o, 1);
        chk("R1 default rd j0", rd_valid_o, 0);
        step(0, 0, 0);
        chk("R1 default length 1", act_o, 0);
        chk("R1 default rd j1", rd_valid_o, 0);
        step(0, 0, 0);
        chk("R1 default latency 3", rd_valid_o, 1);
        step(0, 0, 0);
        chk("R1 default rd ends", rd_valid_o, 0);

        // sweep of lengths, orderings, latencies, starts and directions
        for (int code = 0; code < 4; code++)
            for (int ilv = 0; ilv < 2; ilv++)
                for (int lat = 2; lat < 4; lat++)
                    for (int si = 0; si < 6; si++)
                        for (int wr = 0; wr < 2; wr++) begin
                            int s;
                            case (si)
                                0: s = 0;   1: s = 3;   2: s = 6;
                                3: s = 13;  4: s = 250; default: s = 511;
                            endcase
                            burst(code, ilv, lat, s, wr, s % 4);
                        end

        // R6 full page with wrap, then R8 terminate and drain
        set_mode(7, 1, 3);
        step(2, 2, 505);
        for (int j = 0; j < 10; j++) begin
            chk("R6 full page act", act_o, 1);
            chk("R6 full page col", col_o, (505 + j) % 512);
            chk("R7 full page rd", rd_valid_o, j >= 2);
            if (j < 9) step(0, 0, 0);
        end
        step(4, 0, 0);
        chk("R8 term drops act", act_o, 0);
        chk("R8 drain beat 8", rd_valid_o, 1);
        step(0, 0, 0);
        chk("R8 drain beat 9", rd_valid_o, 1);
        step(0, 0, 0);
        chk("R8 drain done", rd_valid_o, 0);
        step(0, 0, 0);

        // R9 preempt a read burst with a write at beat 2
        set_mode(3, 0, 2);
        step(2, 1, 3);
        for (int j = 0; j < 3; j++) begin
            chk("R9 old col", col_o, 3 + j);
            chk("R9 old rd", rd_valid_o, j >= 1);
            if (j < 2) step(0, 0, 0);
        end
        step(3, 2, 100);
        for (int j = 0; j <= 8; j++) begin
            chk("R9 new act", act_o, j < 8);
            if (j < 8) begin
                chk("R9 new wr", wr_o, 1);
                chk("R9 new bank", bank_o, 2);
                chk("R9 new col", col_o, 96 | ((100 + j) & 7));
            end
            chk("R9 old rd drains", rd_valid_o, j == 0);
            step(0, 0, 0);
        end

        // R10 mode write during a burst and during drain is ignored
        step(2, 0, 16);
        cfg_len_i = 3'd0; cfg_lat_i = 2'd3;
        for (int j = 0; j < 8; j++) begin
            chk("R10 burst keeps running", act_o, 1);
            step(j == 0 ? 1 : 0, 0, 0);
        end
        chk("R10 burst ended", act_o, 0);
        chk("R10 drain pending", rd_valid_o, 1);
        step(1, 0, 0);
        step(0, 0, 0);
        step(0, 0, 0);
        step(2, 3, 40);
        chk("R10 rd at j0 lat2", rd_valid_o, 0);
        for (int j = 1; j < 8; j++) step(0, 0, 0);
        chk("R10 length still 8", act_o, 1);
        chk("R10 latency still 2", rd_valid_o, 1);
        step(0, 0, 0);
        chk("R10 ends after 8", act_o, 0);

        summary();
        $finish;
    end
endmodule